// File: doc/BRIEF.md
# Indirect Peripheral Clock Control Register

The block controls the clocks of up to 64 peripherals through one 32-bit control register. It does not give every peripheral its own register. Software first names a peripheral by its ID, then either reads that peripheral's settings or writes new ones. Each peripheral has two settings: an enable bit and a 2-bit divide shift. Its clock runs at the parent clock rate shifted right by that amount, so it can run undivided or divided by 2, 4 or 8.

The divided clocks leave the block as per-peripheral clock-enable strobes, `clk_en[i]`. Logic that uses a peripheral's clock qualifies its flops with that strobe. Every peripheral has its own free-running counter. A new enable or shift setting reaches the counter only when the counter wraps, so no period is ever cut short. Peripheral IDs 0 and 1 are permanently on and undivided.

The register port is plain control access. A write is taken in any cycle where `wr_en` is high, and the port has no back-pressure. `rd_data` always shows the entry of the most recently selected ID.

Top module: `pcr_indirect_clk_ctrl`

## Requirements
- R1: After reset, every entry with ID 2 or above is disabled with shift 0, the selected ID is 0, and `clk_en` is low for every ID of 2 or above.
- R2: A write with the command bit (bit 12) clear only loads the selected ID from bits 5:0. No entry changes, whatever the other bits hold.
- R3: A write with the command bit set and the enable bit (bit 28) set stores that enable and the shift from bits 17:16 into the entry named by bits 5:0. The write also makes that ID the selected one.
- R4: `rd_data` carries the selected ID in bits 5:0, that entry's shift in bits 17:16 and its enable in bit 28. All other bits read 0. The value is valid from the cycle after the selecting write.
- R5: A write with the command bit set and the enable bit clear disables the named entry. The stored shift is kept, and bits 17:16 of that write are ignored.
- R6: IDs 0 and 1 always read as enabled with shift 0. Command writes to them are ignored, and their `clk_en` is high in every cycle.
- R7: Once settled, an enabled entry with shift s raises `clk_en` for one cycle in every 2^s cycles. A disabled entry never raises `clk_en`.
- R8: A new enable or shift setting takes effect only when the entry's counter wraps. The gap between successive strobes is therefore always a whole old period or a whole new period, never shorter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Parent clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write value (ID, command, shift and enable fields) |
| rd_data | output | 32 | Selected ID and the settings of that ID's entry |
| clk_en | output | 64 | Per-peripheral divided clock-enable strobes |

## Verification
A command write can land in the same cycle as the target counter's wrap, or at any point within the old period. The bench sets one entry to divide by 8. It then writes a divide-by-2 setting at each of the eight phase offsets of that counter. For every phase it records the strobe times and judges them. Each gap must be exactly 8 or exactly 2 cycles, and no 8-cycle gap may follow a 2-cycle gap. That shows the old period completes in full before the new one starts.

// File: rtl/pcr_pkg.sv
package pcr_pkg;
  localparam int ID_W      = 6;
  localparam int SHIFT_W   = 2;
  localparam int REG_W     = 32;
  localparam int ID_LSB    = 0;
  localparam int CMD_POS   = 12;
  localparam int SHIFT_LSB = 16;
  localparam int EN_POS    = 28;

  typedef struct packed {
    logic               cmd;
    logic               en;
    logic [SHIFT_W-1:0] shift;
    logic [ID_W-1:0]    id;
  } pcr_req_t;
endpackage

// File: rtl/pcr_decode.sv
module pcr_decode
  import pcr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic             req_vld,
  output pcr_req_t         req,
  output logic [ID_W-1:0]  sel_id
);
  always_comb begin
    req_vld   = wr_en;
    req.cmd   = wr_data[CMD_POS];
    req.en    = wr_data[EN_POS];
    req.shift = wr_data[SHIFT_LSB +: SHIFT_W];
    req.id    = wr_data[ID_LSB +: ID_W];
  end

  // Any write, with or without the command bit, moves the selection.
  always_ff @(posedge clk) begin
    if (!rst_n)       sel_id <= '0;
    else if (req_vld) sel_id <= req.id;
  end

  a_r2_select_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld |=> (sel_id == $past(req.id)));
endmodule

// File: rtl/pcr_entry_bank.sv
module pcr_entry_bank
  import pcr_pkg::*;
#(
  parameter int NUM_PERIPH = 64,
  parameter int NUM_FIXED  = 2
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               req_vld,
  input  pcr_req_t                           req,
  input  logic [ID_W-1:0]                    sel_id,
  output logic [NUM_PERIPH-1:0]              en_st,
  output logic [NUM_PERIPH-1:0][SHIFT_W-1:0] shift_st,
  output logic                               rd_en,
  output logic [SHIFT_W-1:0]                 rd_shift
);
  for (genvar i = 0; i < NUM_PERIPH; i++) begin : g_entry
    if (i < NUM_FIXED) begin : g_fixed
      assign en_st[i]    = 1'b1;
      assign shift_st[i] = '0;
    end else begin : g_prog
      logic hit;
      assign hit = req_vld && req.cmd && (int'(req.id) == i);
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          en_st[i]    <= 1'b0;
          shift_st[i] <= '0;
        end else if (hit) begin
          en_st[i] <= req.en;
          // A disabling command leaves the stored divider untouched.
          if (req.en) shift_st[i] <= req.shift;
        end
      end
    end
  end

  always_comb begin
    rd_en    = 1'b0;
    rd_shift = '0;
    if (int'(sel_id) < NUM_PERIPH) begin
      rd_en    = en_st[sel_id];
      rd_shift = shift_st[sel_id];
    end
  end

  a_r2_select_keeps_entries: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && !req.cmd) |=> ($stable(en_st) && $stable(shift_st)));

  a_r5_disable_keeps_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && req.cmd && !req.en) |=> $stable(shift_st));

  a_r3_store_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && req.cmd && int'(req.id) >= NUM_FIXED && int'(req.id) < NUM_PERIPH)
    |=> (en_st[$past(req.id)] == $past(req.en)));
endmodule

// File: rtl/pcr_clk_divider.sv
module pcr_clk_divider
  import pcr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_en,
  input  logic [SHIFT_W-1:0] cfg_shift,
  output logic               tick
);
  localparam int CNT_W = (1 << SHIFT_W) - 1;

  logic [CNT_W-1:0]   cnt;
  logic [CNT_W-1:0]   lim;
  logic [SHIFT_W-1:0] act_shift;
  logic               act_en;
  logic               wrap;

  always_comb begin
    lim = '0;
    for (int b = 0; b < CNT_W; b++)
      if (b < int'(act_shift)) lim[b] = 1'b1;
  end

  assign wrap = (cnt == lim);
  assign tick = act_en && (cnt == '0);

  // Settings are sampled only at the wrap, so no period is ever truncated.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      act_shift <= '0;
      act_en    <= 1'b0;
    end else if (wrap) begin
      cnt       <= '0;
      act_shift <= cfg_shift;
      act_en    <= cfg_en;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  a_r8_change_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    !($stable(act_shift) && $stable(act_en)) |-> $past(wrap));

  a_r7_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && act_shift != '0) |=> !tick);
endmodule

// File: rtl/pcr_indirect_clk_ctrl.sv
module pcr_indirect_clk_ctrl
  import pcr_pkg::*;
#(
  parameter int NUM_PERIPH = 64,
  parameter int NUM_FIXED  = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [31:0]           wr_data,
  output logic [31:0]           rd_data,
  output logic [NUM_PERIPH-1:0] clk_en
);
  logic                               req_vld;
  pcr_req_t                           req;
  logic [ID_W-1:0]                    sel_id;
  logic [NUM_PERIPH-1:0]              en_st;
  logic [NUM_PERIPH-1:0][SHIFT_W-1:0] shift_st;
  logic                               rd_en;
  logic [SHIFT_W-1:0]                 rd_shift;

  pcr_decode u_decode (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .req_vld (req_vld),
    .req     (req),
    .sel_id  (sel_id)
  );

  pcr_entry_bank #(.NUM_PERIPH(NUM_PERIPH), .NUM_FIXED(NUM_FIXED)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_vld  (req_vld),
    .req      (req),
    .sel_id   (sel_id),
    .en_st    (en_st),
    .shift_st (shift_st),
    .rd_en    (rd_en),
    .rd_shift (rd_shift)
  );

  for (genvar i = 0; i < NUM_PERIPH; i++) begin : g_clk
    if (i < NUM_FIXED) begin : g_always_on
      assign clk_en[i] = 1'b1;
    end else begin : g_div
      pcr_clk_divider u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_en    (en_st[i]),
        .cfg_shift (shift_st[i]),
        .tick      (clk_en[i])
      );
    end
  end

  always_comb begin
    rd_data                        = '0;
    rd_data[ID_LSB +: ID_W]        = sel_id;
    rd_data[SHIFT_LSB +: SHIFT_W]  = rd_shift;
    rd_data[EN_POS]                = rd_en;
  end

  a_r6_fixed_read: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(sel_id) < NUM_FIXED) |-> (rd_data[EN_POS] && rd_data[SHIFT_LSB +: SHIFT_W] == '0));
endmodule

// File: tb/test_pcr_indirect_clk_ctrl.sv
module test_pcr_indirect_clk_ctrl;
  localparam int N = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [31:0]   wr_data = '0;
  logic [31:0]   rd_data;
  logic [N-1:0]  clk_en;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  int exp_sh[N];
  bit exp_en[N];

  always #4 clk = ~clk;

  pcr_indirect_clk_ctrl i_pcr_indirect_clk_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .clk_en(clk_en)
  );

  function automatic logic [31:0] mk(int id, bit cmd, bit en, int sh);
    logic [31:0] v = '0;
    v[5:0]   = id[5:0];
    v[12]    = cmd;
    v[17:16] = sh[1:0];
    v[28]    = en;
    return v;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic count_ticks(output int cnt[N]);
    for (int i = 0; i < N; i++) cnt[i] = 0;
    for (int c = 0; c < 64; c++) begin
      @(negedge clk);
      for (int i = 0; i < N; i++) if (clk_en[i]) cnt[i]++;
    end
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    int cnt[N];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1, R4, R6: reset state
    chk("R1/R4 reset read", rd_data, 32'h1000_0000);
    chk("R1/R6 reset clk_en", clk_en, 64'h3);
    for (int id = 2; id < N; id++) begin
      wr(mk(id, 0, 0, 0));
      chk("R1 reset entry", rd_data, mk(id, 0, 0, 0));
    end

    // R3: program every entry
    for (int id = 2; id < N; id++) begin
      exp_en[id] = (id % 3) != 0;
      exp_sh[id] = exp_en[id] ? id % 4 : 0;
      wr(mk(id, 1, exp_en[id], id % 4));
      chk("R3 read after command", rd_data, mk(id, 0, exp_en[id], exp_sh[id]));
    end
    exp_en[0] = 1; exp_sh[0] = 0; exp_en[1] = 1; exp_sh[1] = 0;

    // R2, R4: select-only writes with junk in other fields
    for (int id = 0; id < N; id++) begin
      wr(mk(id, 0, !exp_en[id], 3 - exp_sh[id]) | 32'h0440_0f00);
      chk("R2/R4 select only", rd_data, mk(id, 0, exp_en[id], exp_sh[id]));
    end

    // R7: strobe rates
    repeat (20) @(negedge clk);
    count_ticks(cnt);
    for (int id = 0; id < N; id++)
      chk("R7 strobe count", cnt[id], exp_en[id] ? (64 >> exp_sh[id]) : 0);

    // R5: disable keeps shift
    for (int id = 2; id < N; id++) begin
      if (exp_en[id]) begin
        wr(mk(id, 1, 0, (exp_sh[id] + 1) % 4));
        exp_en[id] = 0;
        chk("R5 disable keeps shift", rd_data, mk(id, 0, 0, exp_sh[id]));
      end
    end
    repeat (20) @(negedge clk);
    count_ticks(cnt);
    for (int id = 2; id < N; id++)
      chk("R5/R7 disabled silent", cnt[id], 0);

    // R6: fixed entries ignore commands
    for (int id = 0; id < 2; id++) begin
      wr(mk(id, 1, 0, 3));
      chk("R6 fixed entry read", rd_data, mk(id, 0, 1, 0));
    end
    count_ticks(cnt);
    chk("R6 fixed strobe 0", cnt[0], 64);
    chk("R6 fixed strobe 1", cnt[1], 64);

    // R8: switch divide-by-8 to divide-by-2 at every phase
    for (int p = 0; p < 8; p++) begin
      int last, gap, ok_set, ok_ord, prev_gap;
      wr(mk(5, 1, 1, 3));
      repeat (24) @(negedge clk);
      repeat (p) @(negedge clk);
      wr(mk(5, 1, 1, 1));
      last = -1; ok_set = 1; ok_ord = 1; prev_gap = 8;
      for (int c = 0; c < 40; c++) begin
        if (clk_en[5]) begin
          if (last >= 0) begin
            gap = c - last;
            if (gap != 8 && gap != 2) ok_set = 0;
            if (gap > prev_gap) ok_ord = 0;
            prev_gap = gap;
          end
          last = c;
        end
        @(negedge clk);
      end
      chk("R8 gaps whole periods", ok_set, 1);
      chk("R8 gap order", ok_ord, 1);
      chk("R8 settled to new period", prev_gap, 2);
    end

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
      $finish;
    end
  end
endmodule